// File: doc/BRIEF.md
# Run-Length Connected Component Labeller

The block takes a binary mask image as a one-bit pixel stream, one pixel per valid cycle, with an end-of-line marker on the last pixel of each row and an end-of-frame marker on the last pixel of the frame. Every horizontal stretch of foreground pixels becomes one run record (start column, end column, row) held in on-chip registers. Once the frame closes, the block labels the runs. Each run is compared with the runs on the row below to pass on provisional labels. Where a run meets a run that is already labelled, the conflict is noted in a per-run equivalence field. A resolution pass then merges the conflicting labels until all runs of one connected blob carry the same label.

When resolution ends, a one-cycle done pulse is given. The resolved run records then stream out, one per cycle, in raster order. A mode input selects 4- or 8-connectivity. The run store has a fixed capacity. Runs beyond it are dropped and an overflow flag is shown for the rest of that frame. While the block labels or streams, it is busy and ignores pixels.

Top module: `ccl_rle_labeller`

## Requirements
- R1: Each maximal horizontal stretch of 1-pixels in a row yields one record. Its start and end are the inclusive column numbers, counted from 0 at the first pixel of the row. Its row number counts from 0 at the first row of the frame. eof_i on a pixel also ends its row.
- R2: With adj8_i=0, runs a and b on adjacent rows connect when start_a <= end_b and end_a >= start_b.
- R3: With adj8_i=1, runs a and b on adjacent rows connect when start_a <= end_b+1 and end_a+1 >= start_b.
- R4: After resolution, all runs of one connected blob carry the same label, and runs of different blobs carry different labels.
- R5: Provisional labels 1, 2, 3, ... are given in raster order to the runs that connect to no run on the row above. The final label of a blob is the smallest provisional label inside it, and is never 0.
- R6: The records stream out on consecutive cycles with run_vld_o high, in raster order (row ascending, then start ascending), one record per stored run.
- R7: done_o is high for exactly one cycle, immediately before the first streamed record. It is also given for a frame with no runs.
- R8: If a frame holds more than MAX_RUNS runs, only the first MAX_RUNS are kept, labelled and streamed. ovf_o is then high from the drop through the last streamed record.
- R9: busy_o is high from the cycle after the end-of-frame pixel until the last record has streamed. Pixels presented while busy_o is high have no effect on any frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adj8_i | input | 1 | 1 selects 8-connectivity, 0 selects 4-connectivity; held for a frame |
| pix_vld_i | input | 1 | Pixel valid |
| pix_i | input | 1 | Mask pixel, 1 is foreground |
| eol_i | input | 1 | Last pixel of a row |
| eof_i | input | 1 | Last pixel of the frame |
| busy_o | output | 1 | Labelling or streaming in progress |
| done_o | output | 1 | One-cycle pulse at the end of resolution |
| ovf_o | output | 1 | Run store overflowed in this frame |
| run_vld_o | output | 1 | Streamed record valid |
| run_label_o | output | $clog2(MAX_RUNS+1) | Resolved blob label |
| run_start_o | output | X_W | First column of the run |
| run_end_o | output | X_W | Last column of the run |
| run_row_o | output | Y_W | Row of the run |

## Verification
Two events can fall in the same cycle: the last run of a frame is written into the store, and the frame closes and labelling begins. Overflow can also be raised on that same final run. Both are provoked by frames whose last pixel is foreground: every 3x3 mask is swept in both modes, and an oversized stripe frame drops its final runs at the close. Each case is judged against run lists, provisional labels and blob partitions that the bench builds itself with union-find. Pixels are also driven in the close cycle and throughout labelling, to show that they are ignored.

// File: rtl/ccl_pkg.sv
package ccl_pkg;
  typedef enum logic [2:0] {
    S_COLL, S_LHEAD, S_LSCAN, S_RSCAN, S_RSWEEP, S_DONE, S_STREAM
  } ccl_state_e;
endpackage

// File: rtl/ccl_rle_enc.sv
module ccl_rle_enc #(
  parameter int X_W = 8,
  parameter int Y_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           vld_i,
  input  logic           pix_i,
  input  logic           eol_i,
  input  logic           eof_i,
  output logic           run_vld_o,
  output logic [X_W-1:0] run_s_o,
  output logic [X_W-1:0] run_e_o,
  output logic [Y_W-1:0] run_row_o,
  output logic           fend_o
);
  logic [X_W-1:0] x_q, st_q;
  logic [Y_W-1:0] row_q;
  logic           in_run_q;
  logic           line_end;

  assign line_end = eol_i | eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0; st_q <= '0; row_q <= '0; in_run_q <= 1'b0;
      run_vld_o <= 1'b0; run_s_o <= '0; run_e_o <= '0; run_row_o <= '0;
      fend_o <= 1'b0;
    end else begin
      run_vld_o <= 1'b0;
      fend_o    <= 1'b0;
      if (vld_i) begin
        if (pix_i && line_end) begin
          run_vld_o <= 1'b1;
          run_s_o   <= in_run_q ? st_q : x_q;
          run_e_o   <= x_q;
          run_row_o <= row_q;
        end else if (!pix_i && in_run_q) begin
          run_vld_o <= 1'b1;
          run_s_o   <= st_q;
          run_e_o   <= x_q - X_W'(1);
          run_row_o <= row_q;
        end
        if (pix_i && !in_run_q) st_q <= x_q;
        in_run_q <= pix_i && !line_end;
        x_q      <= line_end ? '0 : x_q + X_W'(1);
        row_q    <= eof_i ? '0 : (eol_i ? row_q + Y_W'(1) : row_q);
        fend_o   <= eof_i;
      end
    end
  end
endmodule

// File: rtl/ccl_ovl.sv
module ccl_ovl #(
  parameter int X_W = 8
) (
  input  logic [X_W-1:0] a_s_i,
  input  logic [X_W-1:0] a_e_i,
  input  logic [X_W-1:0] b_s_i,
  input  logic [X_W-1:0] b_e_i,
  input  logic           adj8_i,
  output logic           hit_o
);
  logic [X_W:0] as_w, ae_w, bs_w, be_w, slack;

  always_comb begin
    as_w  = {1'b0, a_s_i};
    ae_w  = {1'b0, a_e_i};
    bs_w  = {1'b0, b_s_i};
    be_w  = {1'b0, b_e_i};
    slack = {{X_W{1'b0}}, adj8_i};
    hit_o = (as_w <= be_w + slack) && (ae_w + slack >= bs_w);
  end
endmodule

// File: rtl/ccl_rle_labeller.sv
module ccl_rle_labeller
  import ccl_pkg::*;
#(
  parameter int MAX_RUNS = 32,
  parameter int X_W      = 8,
  parameter int Y_W      = 8,
  localparam int IDX_W   = $clog2(MAX_RUNS),
  localparam int CNT_W   = $clog2(MAX_RUNS + 1),
  localparam int LBL_W   = CNT_W,
  localparam int DEPTH   = 2 ** IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adj8_i,
  input  logic             pix_vld_i,
  input  logic             pix_i,
  input  logic             eol_i,
  input  logic             eof_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o,
  output logic             run_vld_o,
  output logic [LBL_W-1:0] run_label_o,
  output logic [X_W-1:0]   run_start_o,
  output logic [X_W-1:0]   run_end_o,
  output logic [Y_W-1:0]   run_row_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_RUNS);

  ccl_state_e st_q;
  logic [LBL_W-1:0] id_q [DEPTH];
  logic [LBL_W-1:0] eq_q [DEPTH];
  logic [X_W-1:0]   rs_q [DEPTH];
  logic [X_W-1:0]   re_q [DEPTH];
  logic [Y_W-1:0]   rr_q [DEPTH];

  logic [CNT_W-1:0] n_q, i_q, j_q, k_q, m_q, p_q;
  logic [LBL_W-1:0] nxt_q, hi_q, lo_q;
  logic             ovf_q, chg_q;

  logic             enc_vld, enc_fend, acc, hit;
  logic [X_W-1:0]   enc_s, enc_e;
  logic [Y_W-1:0]   enc_row;
  logic [IDX_W-1:0] ix_i, ix_j, ix_k, ix_m, ix_p, ix_n;
  logic [Y_W:0]     row_nx, row_j;

  assign acc = pix_vld_i && (st_q == S_COLL) && !enc_fend;

  ccl_rle_enc #(.X_W(X_W), .Y_W(Y_W)) u_enc (
    .clk_i, .rst_ni, .vld_i(acc), .pix_i, .eol_i, .eof_i,
    .run_vld_o(enc_vld), .run_s_o(enc_s), .run_e_o(enc_e),
    .run_row_o(enc_row), .fend_o(enc_fend)
  );

  assign ix_i = i_q[IDX_W-1:0];
  assign ix_j = j_q[IDX_W-1:0];
  assign ix_k = k_q[IDX_W-1:0];
  assign ix_m = m_q[IDX_W-1:0];
  assign ix_p = p_q[IDX_W-1:0];
  assign ix_n = n_q[IDX_W-1:0];

  ccl_ovl #(.X_W(X_W)) u_ovl (
    .a_s_i(rs_q[ix_i]), .a_e_i(re_q[ix_i]),
    .b_s_i(rs_q[ix_j]), .b_e_i(re_q[ix_j]),
    .adj8_i, .hit_o(hit)
  );

  assign row_nx = {1'b0, rr_q[ix_i]} + (Y_W+1)'(1);
  assign row_j  = {1'b0, rr_q[ix_j]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_COLL; n_q <= '0; i_q <= '0; j_q <= '0; k_q <= '0;
      m_q <= '0; p_q <= '0; nxt_q <= LBL_W'(1); hi_q <= '0; lo_q <= '0;
      ovf_q <= 1'b0; chg_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_COLL: begin
          if (enc_vld) begin
            if (n_q == MAX_CNT) ovf_q <= 1'b1;
            else begin
              rs_q[ix_n] <= enc_s; re_q[ix_n] <= enc_e; rr_q[ix_n] <= enc_row;
              id_q[ix_n] <= '0;    eq_q[ix_n] <= '0;
              n_q <= n_q + CNT_W'(1);
            end
          end
          if (enc_fend) begin
            st_q <= S_LHEAD; i_q <= '0; nxt_q <= LBL_W'(1);
          end
        end
        S_LHEAD: begin
          if (i_q == n_q) begin
            st_q <= S_RSCAN; k_q <= '0; chg_q <= 1'b0;
          end else begin
            if (id_q[ix_i] == '0) begin  // no parent above: fresh label
              id_q[ix_i] <= nxt_q; eq_q[ix_i] <= nxt_q;
              nxt_q <= nxt_q + LBL_W'(1);
            end
            j_q  <= i_q + CNT_W'(1);
            st_q <= S_LSCAN;
          end
        end
        S_LSCAN: begin
          if (j_q == n_q || row_j > row_nx) begin
            i_q  <= i_q + CNT_W'(1);
            st_q <= S_LHEAD;
          end else begin
            if (row_j == row_nx && hit) begin
              if (id_q[ix_j] == '0) begin
                id_q[ix_j] <= id_q[ix_i]; eq_q[ix_j] <= id_q[ix_i];
              end else begin
                eq_q[ix_i] <= id_q[ix_j];
              end
            end
            j_q <= j_q + CNT_W'(1);
          end
        end
        S_RSCAN: begin
          if (k_q == n_q) begin
            k_q <= '0; chg_q <= 1'b0;
            if (!chg_q) st_q <= S_DONE;
          end else if (id_q[ix_k] != eq_q[ix_k]) begin
            hi_q <= (id_q[ix_k] > eq_q[ix_k]) ? id_q[ix_k] : eq_q[ix_k];
            lo_q <= (id_q[ix_k] > eq_q[ix_k]) ? eq_q[ix_k] : id_q[ix_k];
            m_q <= '0; chg_q <= 1'b1; st_q <= S_RSWEEP;
          end else begin
            k_q <= k_q + CNT_W'(1);
          end
        end
        S_RSWEEP: begin
          if (id_q[ix_m] == hi_q) id_q[ix_m] <= lo_q;
          if (eq_q[ix_m] == hi_q) eq_q[ix_m] <= lo_q;
          m_q <= m_q + CNT_W'(1);
          if (m_q == n_q - CNT_W'(1)) st_q <= S_RSCAN;
        end
        S_DONE: begin
          p_q <= '0;
          if (n_q == '0) begin
            st_q <= S_COLL; ovf_q <= 1'b0;
          end else st_q <= S_STREAM;
        end
        S_STREAM: begin
          p_q <= p_q + CNT_W'(1);
          if (p_q == n_q - CNT_W'(1)) begin
            st_q <= S_COLL; n_q <= '0; ovf_q <= 1'b0;
          end
        end
        default: st_q <= S_COLL;
      endcase
    end
  end

  assign busy_o      = (st_q != S_COLL) || enc_fend;
  assign done_o      = (st_q == S_DONE);
  assign ovf_o       = ovf_q;
  assign run_vld_o   = (st_q == S_STREAM);
  assign run_label_o = id_q[ix_p];
  assign run_start_o = rs_q[ix_p];
  assign run_end_o   = re_q[ix_p];
  assign run_row_o   = rr_q[ix_p];
endmodule

// File: rtl/ccl_rle_labeller_chk.sv
module ccl_rle_labeller_chk #(
  parameter int X_W   = 8,
  parameter int Y_W   = 8,
  parameter int LBL_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovf_o,
  input logic             run_vld_o,
  input logic [LBL_W-1:0] run_label_o,
  input logic [X_W-1:0]   run_start_o,
  input logic [X_W-1:0]   run_end_o,
  input logic [Y_W-1:0]   run_row_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R7
  AST_STREAM_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_vld_o) |-> $past(done_o)); // R7
  AST_RUN_ORDERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_vld_o |-> run_start_o <= run_end_o); // R1
  AST_LABEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_vld_o |-> run_label_o != '0); // R5
  AST_BUSY_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_vld_o || done_o) |-> busy_o); // R9
  AST_OVF_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_vld_o && $past(run_vld_o)) |-> $stable(ovf_o)); // R8
  AST_RASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_vld_o && $past(run_vld_o)) |->
      (run_row_o > $past(run_row_o) ||
       (run_row_o == $past(run_row_o) && run_start_o > $past(run_end_o)))); // R6
endmodule

bind ccl_rle_labeller ccl_rle_labeller_chk #(.X_W(X_W), .Y_W(Y_W), .LBL_W(LBL_W)) u_chk (.*);

// File: tb/ccl_rle_labeller_bench.sv
module ccl_rle_labeller_bench;
  localparam int MAXR = 16;
  localparam int XW   = 3;
  localparam int YW   = 4;
  localparam int LW   = $clog2(MAXR + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic adj8 = 1'b0, pv = 1'b0, px = 1'b0, eol = 1'b0, eof = 1'b0;
  logic busy, done, ovf, rv;
  logic [LW-1:0] rl;
  logic [XW-1:0] rs, re;
  logic [YW-1:0] rrow;

  int total = 0, bad = 0, cyc = 0;
  bit img [128];
  int m_s [64], m_e [64], m_r [64], m_l [64], par [64];
  int m_n, m_tot;
  bit m_ovf;

  always #5 clk = ~clk;

  ccl_rle_labeller #(.MAX_RUNS(MAXR), .X_W(XW), .Y_W(YW)) u_ccl_rle_labeller (
    .clk_i(clk), .rst_ni(rst_n), .adj8_i(adj8), .pix_vld_i(pv), .pix_i(px),
    .eol_i(eol), .eof_i(eof), .busy_o(busy), .done_o(done), .ovf_o(ovf),
    .run_vld_o(rv), .run_label_o(rl), .run_start_o(rs), .run_end_o(re),
    .run_row_o(rrow)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic bit ovl(int as, int ae, int bs, int be, bit m8);
    if (m8) return (as <= be + 1) && (ae + 1 >= bs);
    return (as <= be) && (ae >= bs);
  endfunction

  function automatic int root(int a);
    int r = a;
    while (par[r] != r) r = par[r];
    return r;
  endfunction

  task automatic model(input int w, input int h, input bit m8);
    int fresh [64];
    int nf;
    bit hp;
    m_n = 0; m_tot = 0;
    for (int y = 0; y < h; y++) begin
      int st = 0;
      for (int x = 0; x < w; x++) begin
        if (img[y*8+x] && (x == 0 || !img[y*8+x-1])) st = x;
        if (img[y*8+x] && (x == w-1 || !img[y*8+x+1])) begin
          if (m_tot < MAXR) begin
            m_s[m_n] = st; m_e[m_n] = x; m_r[m_n] = y; m_n++;
          end
          m_tot++;
        end
      end
    end
    m_ovf = (m_tot > MAXR);
    for (int a = 0; a < m_n; a++) par[a] = a;
    nf = 0;
    for (int b = 0; b < m_n; b++) begin
      hp = 1'b0;
      for (int a = 0; a < b; a++)
        if (m_r[a] == m_r[b] - 1 && ovl(m_s[a], m_e[a], m_s[b], m_e[b], m8)) begin
          int ra, rb;
          hp = 1'b1;
          ra = root(a); rb = root(b);
          if (ra < rb) par[rb] = ra; else par[ra] = rb;
        end
      if (!hp) begin nf++; fresh[b] = nf; end else fresh[b] = 0;
    end
    for (int b = 0; b < m_n; b++) m_l[b] = fresh[root(b)];
  endtask

  task automatic run_frame(input int w, input int h, input bit m8);
    int to;
    string lt;
    model(w, h, m8);
    lt = m8 ? "R3 R4 R5 label" : "R2 R4 R5 label";
    @(negedge clk);
    while (busy) @(negedge clk);
    adj8 = m8;
    for (int y = 0; y < h; y++)
      for (int x = 0; x < w; x++) begin
        pv = 1'b1; px = img[y*8+x]; eol = (x == w-1); eof = (x == w-1) && (y == h-1);
        @(negedge clk);
      end
    // pixels during the close cycle and labelling must be ignored
    px = 1'b1; eol = 1'b1; eof = 1'b1;
    chk(busy == 1'b1, "R9 busy after frame end", busy, 1);
    to = 0;
    while (!done && to < 3000) begin @(negedge clk); to++; end
    chk(done == 1'b1, "R7 done seen", done, 1);
    chk(ovf == m_ovf, "R8 overflow flag", ovf, m_ovf);
    if (m_n == 0) begin pv = 1'b0; px = 1'b0; eol = 1'b0; eof = 1'b0; end
    for (int r = 0; r < m_n; r++) begin
      @(negedge clk);
      if (r == m_n - 1) begin pv = 1'b0; px = 1'b0; eol = 1'b0; eof = 1'b0; end
      chk(rv == 1'b1, "R6 R7 record valid", rv, 1);
      chk(int'(rl) == m_l[r], lt, rl, m_l[r]);
      chk(int'(rs) == m_s[r] && int'(re) == m_e[r], "R1 start/end", {rs, re}, m_s[r]*8 + m_e[r]);
      chk(int'(rrow) == m_r[r], "R1 row", rrow, m_r[r]);
      if (r == m_n - 1) chk(ovf == m_ovf, "R8 overflow held", ovf, m_ovf);
    end
    @(negedge clk);
    chk(rv == 1'b0 && done == 1'b0, "R6 record count", rv, 0);
  endtask

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rv == 1'b0 && ovf == 1'b0, "R9 reset state", {busy, done, rv, ovf}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0, "R9 idle after reset", busy, 0);
    // exhaustive 3x3, both connectivities
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 512; p++) begin
        for (int q = 0; q < 9; q++) img[(q/3)*8 + q%3] = p[q];
        run_frame(3, 3, m[0]);
      end
    // pseudo-random 8x6 masks, overflow possible
    lf = 16'hACE1;
    for (int f = 0; f < 80; f++) begin
      for (int q = 0; q < 48; q++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        img[(q/8)*8 + q%8] = lf[0] & (lf[3] | lf[7]);
      end
      run_frame(8, 6, f[0]);
    end
    // stripes 101010 over 8 rows: 24 runs, store keeps 16 (R8)
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 6; x++) img[y*8+x] = ~x[0];
    run_frame(6, 8, 1'b0);
    run_frame(6, 8, 1'b1);
    // diagonal staircase: joined only in 8-connectivity (R3 vs R2)
    for (int q = 0; q < 128; q++) img[q] = 1'b0;
    for (int y = 0; y < 6; y++) img[y*8+y] = 1'b1;
    run_frame(6, 6, 1'b0);
    run_frame(6, 6, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule